// File: doc/BRIEF.md
# Multiplexer-Steered Ripple-Carry ALU

This block is a purely combinational arithmetic and logic unit of parameterised width (16 bits by default). It is built from one bit slice repeated across the word. In each slice a four-way operand selector feeds the second input of a full adder. The choices are constant zero, constant one, the B bit, or the inverted B bit. The carry ripples from bit 0 up to the top bit, with no lookahead.

All arithmetic operations come from the same adder chain: transfer, increment, addition, subtraction and decrement. The only things that change between them are the operand choice and the carry input. A two-way output selector in every slice can replace the sum bit with one of four bitwise logic terms of that slice. The top select bit chooses between the arithmetic and logic paths. The block drives a result word, a carry-out and a signed overflow flag, and it is used wherever a single-cycle ALU sits inside a registered datapath.

Top module: `alu_mux_ripple`

## Requirements
- R1: With op_sel = 3'b000 the result is (op_a + carry_in) mod 2^N, and carry_out is bit N of that sum. This gives a transfer when carry_in = 0 and an increment when carry_in = 1.
- R2: With op_sel = 3'b001 the result is (op_a + op_b + carry_in) mod 2^N.
- R3: With op_sel = 3'b010 the adder takes the bitwise inverse of op_b, so the result is (op_a + ~op_b + carry_in) mod 2^N. With carry_in = 1 this is op_a - op_b, and carry_out = 1 means no borrow occurred.
- R4: With op_sel = 3'b011 the adder takes all ones, so the result is (op_a + 2^N - 1 + carry_in) mod 2^N. With carry_in = 0 this is op_a - 1.
- R5: With op_sel = 3'b100 the result is op_a AND op_b.
- R6: With op_sel = 3'b101 the result is op_a OR op_b.
- R7: With op_sel = 3'b110 the result is op_a XOR op_b.
- R8: With op_sel = 3'b111 the result is op_a XNOR op_b.
- R9: Whenever op_sel[2] = 1, carry_out and overflow are both 0, and carry_in has no effect on any output.
- R10: Whenever op_sel[2] = 0, overflow is 1 exactly when the two's-complement sum of op_a, the selected second operand (zero, op_b, ~op_b or all ones, each read as signed) and carry_in falls outside the signed N-bit range.
- R11: Whenever op_sel[2] = 0, carry_out equals bit N of the (N+1)-bit sum of op_a, the selected second operand and carry_in.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_a | input | N (16) | First operand, always the first adder input |
| op_b | input | N (16) | Second operand, passed through the operand selector |
| op_sel | input | 3 | Bit 2 chooses logic mode; bits 1:0 choose the operand or the logic term |
| carry_in | input | 1 | Carry into bit 0 of the adder chain |
| result | output | N (16) | Result word |
| carry_out | output | 1 | Carry out of the top slice; 0 in logic mode |
| overflow | output | 1 | Signed overflow; 0 in logic mode |

## Verification
The assertions check the outputs immediately. They assume the inputs are known values and that the combinational paths have settled, so they skip any evaluation where an input is unknown. The stimulus keeps to these assumptions because every input changes only at a clock edge and the outputs are read half a period later. Every operand and carry combination is legal for this block, so the random operands are unconstrained across all select codes and both carry values. Directed corner words are added to cover wraparound and signed overflow: zero, all ones, the most negative value and the most positive value.

// File: rtl/alu_mux_pkg.sv
package alu_mux_pkg;

  typedef enum logic [1:0] {
    OPND_ZERO = 2'b00,
    OPND_B    = 2'b01,
    OPND_NOTB = 2'b10,
    OPND_ONES = 2'b11
  } opnd_sel_e;

  typedef enum logic [1:0] {
    LOGIC_AND  = 2'b00,
    LOGIC_OR   = 2'b01,
    LOGIC_XOR  = 2'b10,
    LOGIC_XNOR = 2'b11
  } logic_sel_e;

  typedef struct packed {
    logic sum;
    logic carry;
    logic t_and;
    logic t_or;
    logic t_xor;
    logic t_xnor;
  } slice_terms_t;

  function automatic logic pick_operand(input logic b_bit, input opnd_sel_e s);
    logic o;
    unique case (s)
      OPND_ZERO: o = 1'b0;
      OPND_B:    o = b_bit;
      OPND_NOTB: o = ~b_bit;
      default:   o = 1'b1;
    endcase
    return o;
  endfunction

  function automatic logic fa_sum(input logic x, input logic y, input logic ci);
    return x ^ y ^ ci;
  endfunction

  function automatic logic fa_carry(input logic x, input logic y, input logic ci);
    return (x & y) | (ci & (x ^ y));
  endfunction

  function automatic logic pick_logic(input slice_terms_t t, input logic_sel_e s);
    logic o;
    unique case (s)
      LOGIC_AND: o = t.t_and;
      LOGIC_OR:  o = t.t_or;
      LOGIC_XOR: o = t.t_xor;
      default:   o = t.t_xnor;
    endcase
    return o;
  endfunction

endpackage

// File: rtl/alu_operand_mux.sv
module alu_operand_mux
  import alu_mux_pkg::*;
(
  input  logic       b_bit,
  input  logic [1:0] opnd_sel,
  output logic       opnd_bit
);
  always_comb begin
    opnd_bit = pick_operand(b_bit, opnd_sel_e'(opnd_sel));
  end
endmodule

// File: rtl/alu_full_adder.sv
module alu_full_adder
  import alu_mux_pkg::*;
(
  input  logic         a_bit,
  input  logic         y_bit,
  input  logic         b_bit,
  input  logic         c_in,
  output slice_terms_t terms
);
  // Adder terms use the steered operand; logic terms use the raw B bit.
  always_comb begin
    terms.sum    = fa_sum(a_bit, y_bit, c_in);
    terms.carry  = fa_carry(a_bit, y_bit, c_in);
    terms.t_and  = a_bit & b_bit;
    terms.t_or   = a_bit | b_bit;
    terms.t_xor  = a_bit ^ b_bit;
    terms.t_xnor = ~terms.t_xor;
  end
endmodule

// File: rtl/alu_out_mux.sv
module alu_out_mux
  import alu_mux_pkg::*;
(
  input  slice_terms_t terms,
  input  logic         logic_mode,
  input  logic [1:0]   func_sel,
  output logic         y_bit
);
  logic logic_bit;
  always_comb begin
    logic_bit = pick_logic(terms, logic_sel_e'(func_sel));
    y_bit     = logic_mode ? logic_bit : terms.sum;
  end
endmodule

// File: rtl/alu_bit_slice.sv
module alu_bit_slice
  import alu_mux_pkg::*;
(
  input  logic       a_bit,
  input  logic       b_bit,
  input  logic [2:0] op_sel,
  input  logic       c_in,
  output logic       opnd_bit,
  output logic       c_out,
  output logic       y_bit
);
  slice_terms_t terms;

  alu_operand_mux u_opnd (
    .b_bit   (b_bit),
    .opnd_sel(op_sel[1:0]),
    .opnd_bit(opnd_bit)
  );

  alu_full_adder u_fa (
    .a_bit(a_bit),
    .y_bit(opnd_bit),
    .b_bit(b_bit),
    .c_in (c_in),
    .terms(terms)
  );

  alu_out_mux u_omux (
    .terms     (terms),
    .logic_mode(op_sel[2]),
    .func_sel  (op_sel[1:0]),
    .y_bit     (y_bit)
  );

  assign c_out = terms.carry;
endmodule

// File: rtl/alu_mux_ripple.sv
module alu_mux_ripple #(
  parameter int N = 16
) (
  input  logic [N-1:0] op_a,
  input  logic [N-1:0] op_b,
  input  logic [2:0]   op_sel,
  input  logic         carry_in,
  output logic [N-1:0] result,
  output logic         carry_out,
  output logic         overflow
);
  localparam int MSB = N - 1;

  // Named internal events for the checker.
  logic [N:0]   carry_w;
  logic [N-1:0] opnd_w;
  logic         logic_mode_w;

  assign carry_w[0]   = carry_in;
  assign logic_mode_w = op_sel[2];

  for (genvar i = 0; i < N; i++) begin : g_slice
    alu_bit_slice u_slice (
      .a_bit   (op_a[i]),
      .b_bit   (op_b[i]),
      .op_sel  (op_sel),
      .c_in    (carry_w[i]),
      .opnd_bit(opnd_w[i]),
      .c_out   (carry_w[i+1]),
      .y_bit   (result[i])
    );
  end

  assign carry_out = logic_mode_w ? 1'b0 : carry_w[N];
  assign overflow  = logic_mode_w ? 1'b0 : (carry_w[MSB] ^ carry_w[N]);
endmodule

// File: rtl/alu_mux_ripple_chk.sv
module alu_mux_ripple_chk #(
  parameter int N = 16
) (
  input logic [N-1:0] a,
  input logic [N-1:0] b,
  input logic [2:0]   sel,
  input logic         cin,
  input logic [N-1:0] res,
  input logic         cout,
  input logic         ovf,
  input logic [N:0]   carry,
  input logic [N-1:0] opnd
);
  logic [N:0]   wide_sum;
  logic [N-1:0] want_opnd;

  always_comb begin
    case (sel[1:0])
      2'b00:   want_opnd = '0;
      2'b01:   want_opnd = b;
      2'b10:   want_opnd = ~b;
      default: want_opnd = '1;
    endcase
    wide_sum = {1'b0, a} + {1'b0, want_opnd} + {{N{1'b0}}, cin};
    if (!$isunknown({a, b, sel, cin})) begin
      // R1 R2 R3 R4: the steered operand reaches the adder chain
      p_operand_r3: assert (sel[2] || opnd == want_opnd);
      // R1 R2 R4: result word of the adder chain
      p_arith_sum_r2: assert (sel[2] || res == wide_sum[N-1:0]);
      p_carry_entry_r11: assert (carry[0] == cin);
      p_carry_exit_r11: assert (sel[2] || cout == wide_sum[N]);
      p_ovf_sign_r10: assert (sel[2] ||
        ovf == ((a[N-1] == want_opnd[N-1]) && (res[N-1] != a[N-1])));
      p_no_overflow_r9: assert (!sel[2] || (!cout && !ovf));
      p_and_r5:  assert (sel != 3'b100 || res == (a & b));
      p_or_r6:   assert (sel != 3'b101 || res == (a | b));
      p_xor_r7:  assert (sel != 3'b110 || res == (a ^ b));
      p_xnor_r8: assert (sel != 3'b111 || res == ~(a ^ b));
    end
  end
endmodule

bind alu_mux_ripple alu_mux_ripple_chk #(.N(N)) u_chk (
  .a    (op_a),
  .b    (op_b),
  .sel  (op_sel),
  .cin  (carry_in),
  .res  (result),
  .cout (carry_out),
  .ovf  (overflow),
  .carry(carry_w),
  .opnd (opnd_w)
);

// File: tb/test_alu_mux_ripple.sv
module test_alu_mux_ripple;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic [15:0] op_a = '0, op_b = '0;
  logic [2:0]  op_sel = '0;
  logic        carry_in = 1'b0;
  logic [15:0] result;
  logic        carry_out, overflow;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  alu_mux_ripple #(.N(16)) i_alu_mux_ripple (
    .op_a(op_a), .op_b(op_b), .op_sel(op_sel), .carry_in(carry_in),
    .result(result), .carry_out(carry_out), .overflow(overflow)
  );

  task automatic chk(input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h (a=%h b=%h sel=%b cin=%b)",
               tag, what, act, exp, op_a, op_b, op_sel, carry_in);
    end
  endtask

  // Second operand as a signed value, per the requirement encodings
  function automatic int second_signed(input logic [1:0] s, input logic [15:0] b);
    case (s)
      2'b00:   return 0;
      2'b01:   return int'($signed(b));
      2'b10:   return int'($signed(~b));
      default: return -1;
    endcase
  endfunction

  function automatic int second_unsigned(input logic [1:0] s, input logic [15:0] b);
    case (s)
      2'b00:   return 0;
      2'b01:   return int'(b);
      2'b10:   return 65535 - int'(b);
      default: return 65535;
    endcase
  endfunction

  task automatic apply_and_check(input logic [15:0] a, input logic [15:0] b,
                                 input logic [2:0] s, input logic c);
    int u, sg;
    logic [15:0] er;
    string tag;
    @(posedge clk);
    op_a = a; op_b = b; op_sel = s; carry_in = c;
    @(negedge clk);
    if (!s[2]) begin
      u  = int'(a) + second_unsigned(s[1:0], b) + int'(c);
      sg = int'($signed(a)) + second_signed(s[1:0], b) + int'(c);
      er = u[15:0];
      case (s[1:0])
        2'b00: tag = "R1";
        2'b01: tag = "R2";
        2'b10: tag = "R3";
        default: tag = "R4";
      endcase
      chk(tag, "result", 32'(result), 32'(er));
      chk("R11", "carry_out", 32'(carry_out), 32'(u >= 65536));
      chk("R10", "overflow", 32'(overflow), 32'((sg > 32767) || (sg < -32768)));
    end else begin
      case (s[1:0])
        2'b00: begin tag = "R5"; er = a & b; end
        2'b01: begin tag = "R6"; er = a | b; end
        2'b10: begin tag = "R7"; er = a ^ b; end
        default: begin tag = "R8"; er = ~(a ^ b); end
      endcase
      chk(tag, "result", 32'(result), 32'(er));
      chk("R9", "carry_out", 32'(carry_out), 32'd0);
      chk("R9", "overflow", 32'(overflow), 32'd0);
    end
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin : stim
    logic [15:0] corners [4];
    int seed;
    logic [15:0] ra, rb;
    logic [15:0] keep;
    corners[0] = 16'h0000; corners[1] = 16'hFFFF;
    corners[2] = 16'h8000; corners[3] = 16'h7FFF;
    seed = 32'h1234_5678;
    void'($urandom(seed));

    // Idle state: all-zero inputs give a zero transfer
    @(negedge clk);
    chk("R1", "idle result", 32'(result), 32'd0);
    chk("R11", "idle carry_out", 32'(carry_out), 32'd0);

    // Directed: R1 increment wrap, R3 subtract, R4 decrement
    apply_and_check(16'hFFFF, 16'h0000, 3'b000, 1'b1);
    apply_and_check(16'h0005, 16'h0007, 3'b010, 1'b1);
    apply_and_check(16'h0000, 16'h1234, 3'b011, 1'b0);
    apply_and_check(16'h7FFF, 16'h0001, 3'b001, 1'b0);

    // R9: carry_in ignored in logic mode, compare result with both carry values
    for (int s = 4; s < 8; s++) begin
      apply_and_check(16'hA5C3, 16'h0FF0, 3'(s), 1'b0);
      keep = result;
      apply_and_check(16'hA5C3, 16'h0FF0, 3'(s), 1'b1);
      chk("R9", "cin has no effect", 32'(result), 32'(keep));
    end

    // Corner sweep over all codes and carries
    for (int i = 0; i < 4; i++)
      for (int j = 0; j < 4; j++)
        for (int s = 0; s < 8; s++)
          for (int c = 0; c < 2; c++)
            apply_and_check(corners[i], corners[j], 3'(s), 1'(c));

    // Random sweep
    for (int k = 0; k < 3000; k++) begin
      ra = 16'($urandom);
      rb = 16'($urandom);
      apply_and_check(ra, rb, 3'($urandom), 1'($urandom));
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule